// File: doc/BRIEF.md
# Instruction Decode and Step Sequencer

This block sits between instruction fetch and the datapath of a small load/store machine with eight 16-bit registers. When the fetch side signals that a new 16-bit instruction word is present, the block captures the word and splits it into register selectors, a sign-extended immediate and a 10-bit address. It classifies the 3-bit primary opcode into datapath control strobes. The ALU, register file, comparator and data memory are outside the block. They consume these controls.

Each captured instruction is walked through a short fixed sequence of steps: hold, execute and advance. The program-counter enable stays low until the last step and is raised for exactly one cycle there. The unconditional jump leaves out the hold step. Register and memory writes are issued only in the execute step, so the datapath has a single, predictable commit cycle. All outputs come from registers and change together with the sequencer state.

Top module: `instr_seq_top`

## Requirements
- R1: The selectors are taken from the captured word and held until the next capture: `sel_dst` = bits [12:10] (destination for ALU/load, store source, jump condition code), `sel_src1` = bits [9:7], `sel_op1` = bits [5:3], `sel_src2` = bits [2:0].
- R2: `imm_ext` is bits [6:0] of the captured word sign-extended to 16 bits. `addr` is bits [9:0] of the captured word.
- R3: The opcode in bits [15:13] is encoded as 000 AND, 001 ADD, 010 ANDI, 011 ADDI, 100 LD, 101 ST, 110 CMP and 111 jump family. While an instruction is active (hold, execute or advance), `is_alu` is 1 for 000–011, `imm_sel` is 1 for 010 and 011, `alu_add` is 1 for 001 and 011, `mem_rd` is 1 for 100, `is_cmp` is 1 for 110 and `is_jump` is 1 for 111. When no instruction is active, all six are 0.
- R4: An instruction other than the unconditional jump produces one hold cycle, then one execute cycle, then one advance cycle. The hold cycle is the first output cycle after the clock edge that captures the word. After the advance cycle the block is idle.
- R5: The unconditional jump (opcode 111 with bits [12:10] = 000) skips the hold step. Its execute cycle is the first output cycle after capture, and its advance cycle follows.
- R6: `pc_en` is 1 only in the advance cycle: exactly one cycle per instruction, and 0 in all other cycles.
- R7: `reg_we` is 1 only in the execute cycle, and only for opcodes 000–100. `mem_wr` is 1 only in the execute cycle, and only for opcode 101.
- R8: `fetch_go` is honoured only at an edge where the block is idle. While an instruction is active, `fetch_go` and changes on `instr` have no effect on any output.
- R9: A synchronous active-high `rst` makes the block idle and drives every strobe low, and every selector, `imm_ext` and `addr` to zero. It has priority over `fetch_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_go | input | 1 | A new instruction word is present on `instr` |
| instr | input | 16 | Instruction word |
| pc_en | output | 1 | Program counter may advance |
| reg_we | output | 1 | Register file write strobe |
| mem_rd | output | 1 | Data memory read (load) |
| mem_wr | output | 1 | Data memory write strobe (store) |
| is_alu | output | 1 | ALU-class instruction |
| is_cmp | output | 1 | Compare instruction |
| is_jump | output | 1 | Jump-family instruction |
| imm_sel | output | 1 | ALU second operand from immediate |
| alu_add | output | 1 | ALU adds (1) or ANDs (0) |
| sel_dst | output | 3 | Bits [12:10]: destination, store source or jump condition |
| sel_src1 | output | 3 | Bits [9:7]: first ALU source |
| sel_src2 | output | 3 | Bits [2:0]: second ALU source |
| sel_op1 | output | 3 | Bits [5:3]: operand 1 |
| imm_ext | output | 16 | Sign-extended 7-bit immediate |
| addr | output | 10 | Address field |

## Verification
The assertions assume that `rst` is held for at least one edge before any instruction is issued. They also assume that the fetch side may raise `fetch_go` at any time, including during an active instruction, so acceptance depends only on the block's own idle state. The stimulus keeps `rst` high for several cycles at the start and again once mid-sequence. It then drives directed words for every opcode and jump condition, words that hold `fetch_go` high continuously while `instr` changes, and a long run of random words with random `fetch_go`. All inputs change only on the falling clock edge.

// File: rtl/isd_pkg.sv
package isd_pkg;
  localparam int OPW = 3;

  localparam logic [OPW-1:0] OP_AND  = 3'b000;
  localparam logic [OPW-1:0] OP_ADD  = 3'b001;
  localparam logic [OPW-1:0] OP_ANDI = 3'b010;
  localparam logic [OPW-1:0] OP_ADDI = 3'b011;
  localparam logic [OPW-1:0] OP_LD   = 3'b100;
  localparam logic [OPW-1:0] OP_ST   = 3'b101;
  localparam logic [OPW-1:0] OP_CMP  = 3'b110;
  localparam logic [OPW-1:0] OP_JMP  = 3'b111;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HOLD = 2'd1,
    PH_EXEC = 2'd2,
    PH_ADV  = 2'd3
  } phase_t;

  typedef struct packed {
    logic imm_sel;
    logic alu_add;
    logic is_alu;
    logic is_cmp;
    logic mem_rd;
    logic is_st;
    logic is_jump;
    logic wr_reg;
    logic uncond;
  } klass_t;
endpackage

// File: rtl/isd_fields.sv
module isd_fields #(
  parameter int IW   = 16,
  parameter int RIW  = 3,
  parameter int DW   = 16,
  parameter int IMMW = 7,
  parameter int AW   = 10
) (
  input  logic [IW-1:0]  word,
  output logic [RIW-1:0] f_dst,
  output logic [RIW-1:0] f_src1,
  output logic [RIW-1:0] f_src2,
  output logic [RIW-1:0] f_op1,
  output logic [DW-1:0]  f_imm,
  output logic [AW-1:0]  f_addr
);
  localparam int DST_HI  = IW - isd_pkg::OPW - 1;
  localparam int SRC1_HI = DST_HI - RIW;
  localparam int OP1_HI  = 2 * RIW - 1;
  localparam int EXT     = DW - IMMW;

  always_comb begin
    f_dst  = word[DST_HI -: RIW];
    f_src1 = word[SRC1_HI -: RIW];
    f_op1  = word[OP1_HI -: RIW];
    f_src2 = word[RIW-1:0];
    f_imm  = {{EXT{word[IMMW-1]}}, word[IMMW-1:0]};
    f_addr = word[AW-1:0];
  end
endmodule

// File: rtl/isd_class.sv
module isd_class #(
  parameter int IW  = 16,
  parameter int RIW = 3,
  parameter logic [RIW-1:0] ALWAYS_CODE = '0
) (
  input  logic [IW-1:0]  word,
  output isd_pkg::klass_t k
);
  import isd_pkg::*;
  localparam int SUB_HI = IW - OPW - 1;

  logic [OPW-1:0] op;
  logic [RIW-1:0] sub;

  always_comb begin
    op  = word[IW-1 -: OPW];
    sub = word[SUB_HI -: RIW];
    k   = '0;
    unique case (op)
      OP_AND:  begin k.is_alu = 1'b1; k.wr_reg = 1'b1; end
      OP_ADD:  begin k.is_alu = 1'b1; k.wr_reg = 1'b1; k.alu_add = 1'b1; end
      OP_ANDI: begin k.is_alu = 1'b1; k.wr_reg = 1'b1; k.imm_sel = 1'b1; end
      OP_ADDI: begin
        k.is_alu  = 1'b1;
        k.wr_reg  = 1'b1;
        k.imm_sel = 1'b1;
        k.alu_add = 1'b1;
      end
      OP_LD:   begin k.mem_rd = 1'b1; k.wr_reg = 1'b1; end
      OP_ST:   k.is_st  = 1'b1;
      OP_CMP:  k.is_cmp = 1'b1;
      OP_JMP:  begin k.is_jump = 1'b1; k.uncond = (sub == ALWAYS_CODE); end
      default: k = '0;
    endcase
  end
endmodule

// File: rtl/isd_seq.sv
module isd_seq (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic            skip_hold,
  output logic            accept,
  output isd_pkg::phase_t ph_q,
  output isd_pkg::phase_t ph_nx
);
  import isd_pkg::*;

  always_comb begin
    accept = (ph_q == PH_IDLE) && go;
    unique case (ph_q)
      PH_IDLE: ph_nx = go ? (skip_hold ? PH_EXEC : PH_HOLD) : PH_IDLE;
      PH_HOLD: ph_nx = PH_EXEC;
      PH_EXEC: ph_nx = PH_ADV;
      PH_ADV:  ph_nx = PH_IDLE;
      default: ph_nx = PH_IDLE;
    endcase
    if (rst) ph_nx = PH_IDLE;
  end

  always_ff @(posedge clk) begin
    ph_q <= ph_nx;
  end
endmodule

// File: rtl/instr_seq_top.sv
module instr_seq_top #(
  parameter int IW   = 16,
  parameter int RIW  = 3,
  parameter int DW   = 16,
  parameter int IMMW = 7,
  parameter int AW   = 10,
  parameter logic [RIW-1:0] ALWAYS_CODE = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fetch_go,
  input  logic [IW-1:0]  instr,
  output logic           pc_en,
  output logic           reg_we,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           is_alu,
  output logic           is_cmp,
  output logic           is_jump,
  output logic           imm_sel,
  output logic           alu_add,
  output logic [RIW-1:0] sel_dst,
  output logic [RIW-1:0] sel_src1,
  output logic [RIW-1:0] sel_src2,
  output logic [RIW-1:0] sel_op1,
  output logic [DW-1:0]  imm_ext,
  output logic [AW-1:0]  addr
);
  import isd_pkg::*;

  logic [IW-1:0] ir_q, ir_nx;
  logic          accept;
  phase_t        ph_q, ph_nx;
  klass_t        kls;
  logic          active_nx;

  logic [RIW-1:0] n_dst, n_src1, n_src2, n_op1;
  logic [DW-1:0]  n_imm;
  logic [AW-1:0]  n_addr;

  always_comb begin
    if (rst)         ir_nx = '0;
    else if (accept) ir_nx = instr;
    else             ir_nx = ir_q;
  end

  always_ff @(posedge clk) begin
    ir_q <= ir_nx;
  end

  isd_class #(.IW(IW), .RIW(RIW), .ALWAYS_CODE(ALWAYS_CODE)) u_class (
    .word (ir_nx),
    .k    (kls)
  );

  isd_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .go        (fetch_go),
    .skip_hold (kls.uncond),
    .accept    (accept),
    .ph_q      (ph_q),
    .ph_nx     (ph_nx)
  );

  isd_fields #(.IW(IW), .RIW(RIW), .DW(DW), .IMMW(IMMW), .AW(AW)) u_fields (
    .word   (ir_nx),
    .f_dst  (n_dst),
    .f_src1 (n_src1),
    .f_src2 (n_src2),
    .f_op1  (n_op1),
    .f_imm  (n_imm),
    .f_addr (n_addr)
  );

  assign active_nx = (ph_nx != PH_IDLE);

  always_ff @(posedge clk) begin
    pc_en    <= (ph_nx == PH_ADV);
    reg_we   <= (ph_nx == PH_EXEC) && kls.wr_reg;
    mem_wr   <= (ph_nx == PH_EXEC) && kls.is_st;
    mem_rd   <= active_nx && kls.mem_rd;
    is_alu   <= active_nx && kls.is_alu;
    is_cmp   <= active_nx && kls.is_cmp;
    is_jump  <= active_nx && kls.is_jump;
    imm_sel  <= active_nx && kls.imm_sel;
    alu_add  <= active_nx && kls.alu_add;
    sel_dst  <= n_dst;
    sel_src1 <= n_src1;
    sel_src2 <= n_src2;
    sel_op1  <= n_op1;
    imm_ext  <= n_imm;
    addr     <= n_addr;
  end
endmodule

// File: rtl/instr_seq_chk.sv
module instr_seq_chk #(
  parameter int RIW  = 3,
  parameter int DW   = 16,
  parameter int IMMW = 7
) (
  input logic           clk,
  input logic           rst,
  input logic           pc_en,
  input logic           reg_we,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic           is_alu,
  input logic           is_cmp,
  input logic           is_jump,
  input logic           imm_sel,
  input logic           alu_add,
  input logic [RIW-1:0] sel_dst,
  input logic [RIW-1:0] sel_src1,
  input logic [RIW-1:0] sel_src2,
  input logic [RIW-1:0] sel_op1,
  input logic [DW-1:0]  imm_ext
);
  a_r6_pc_single: assert property (@(posedge clk) disable iff (rst)
    pc_en |=> !pc_en);

  a_r7_commit_then_adv: assert property (@(posedge clk) disable iff (rst)
    (reg_we || mem_wr) |=> pc_en);

  a_r7_no_commit_on_adv: assert property (@(posedge clk) disable iff (rst)
    pc_en |-> !(reg_we || mem_wr));

  a_r3_one_class: assert property (@(posedge clk) disable iff (rst)
    $onehot0({is_alu, mem_rd, is_cmp, is_jump}));

  a_r3_imm_is_alu: assert property (@(posedge clk) disable iff (rst)
    (imm_sel || alu_add) |-> is_alu);

  a_r7_we_class: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> (is_alu || mem_rd));

  a_r2_sign_ext: assert property (@(posedge clk) disable iff (rst)
    imm_ext[DW-1:IMMW] == {(DW-IMMW){imm_ext[IMMW-1]}});

  a_r8_fields_held: assert property (@(posedge clk) disable iff (rst)
    pc_en |-> ($stable(sel_dst) && $stable(sel_src1) && $stable(sel_src2)
               && $stable(sel_op1) && $stable(imm_ext)));

  a_r9_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !(pc_en || reg_we || mem_wr || mem_rd || is_alu
                     || is_cmp || is_jump) && imm_ext == '0);
endmodule

bind instr_seq_top instr_seq_chk #(.RIW(RIW), .DW(DW), .IMMW(IMMW)) u_chk (.*);

// File: tb/sim_instr_seq_top.sv
`timescale 1ns/1ps
module sim_instr_seq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_go = 1'b0;
  logic [15:0] instr = 16'h0;
  logic        pc_en, reg_we, mem_rd, mem_wr, is_alu, is_cmp, is_jump, imm_sel, alu_add;
  logic [2:0]  sel_dst, sel_src1, sel_src2, sel_op1;
  logic [15:0] imm_ext;
  logic [9:0]  addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  instr_seq_top u0 (
    .clk(clk), .rst(rst), .fetch_go(fetch_go), .instr(instr),
    .pc_en(pc_en), .reg_we(reg_we), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .is_alu(is_alu), .is_cmp(is_cmp), .is_jump(is_jump),
    .imm_sel(imm_sel), .alu_add(alu_add),
    .sel_dst(sel_dst), .sel_src1(sel_src1), .sel_src2(sel_src2), .sel_op1(sel_op1),
    .imm_ext(imm_ext), .addr(addr)
  );

  // Reference model: 0 idle, 1 hold, 2 execute, 3 advance
  int          m_ph = 0;
  int          m_q[$];
  logic [15:0] m_w = 16'h0;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0;
      m_q.delete();
      m_w  = 16'h0;
    end else if (m_q.size() > 0) begin
      m_ph = m_q.pop_front();
    end else if (m_ph == 0 && fetch_go) begin
      m_w = instr;
      if (instr[15:13] == 3'd7 && instr[12:10] == 3'd0) m_q = '{3};
      else                                              m_q = '{2, 3};
      m_ph = (instr[15:13] == 3'd7 && instr[12:10] == 3'd0) ? 2 : 1;
    end else begin
      m_ph = 0;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      int  op;
      bit  act;
      op  = m_w[15:13];
      act = (m_ph != 0);
      check("R1 sel_dst",  sel_dst,  m_w[12:10]);
      check("R1 sel_src1", sel_src1, m_w[9:7]);
      check("R1 sel_op1",  sel_op1,  m_w[5:3]);
      check("R1 sel_src2", sel_src2, m_w[2:0]);
      check("R2 imm_ext",  imm_ext,  {{9{m_w[6]}}, m_w[6:0]});
      check("R2 addr",     addr,     m_w[9:0]);
      check("R3 is_alu",   is_alu,   act && op <= 3);
      check("R3 imm_sel",  imm_sel,  act && (op == 2 || op == 3));
      check("R3 alu_add",  alu_add,  act && (op == 1 || op == 3));
      check("R3 mem_rd",   mem_rd,   act && op == 4);
      check("R3 is_cmp",   is_cmp,   act && op == 6);
      check("R3 is_jump",  is_jump,  act && op == 7);
      check("R6 pc_en",    pc_en,    m_ph == 3);
      check("R7 reg_we",   reg_we,   m_ph == 2 && op <= 4);
      check("R7 mem_wr",   mem_wr,   m_ph == 2 && op == 5);
    end
  end

  task automatic issue(logic [15:0] w);
    @(negedge clk);
    fetch_go = 1'b1;
    instr    = w;
    @(negedge clk);
    fetch_go = 1'b0;
    instr    = ~w;
  endtask

  // cycles from the capturing edge until pc_en is seen high
  task automatic latency(logic [15:0] w, int exp, string tag);
    int n;
    @(negedge clk);
    fetch_go = 1'b1;
    instr    = w;
    n = 0;
    do begin
      @(negedge clk);
      fetch_go = 1'b0;
      n++;
    end while (!pc_en && n < 10);
    check(tag, n, exp);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #700000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state at the ports
    check("R9 pc_en reset",   pc_en,   0);
    check("R9 reg_we reset",  reg_we,  0);
    check("R9 imm_ext reset", imm_ext, 0);
    check("R9 sel_dst reset", sel_dst, 0);
    rst = 1'b0;

    // every opcode, assorted fields and immediates at the sign boundary
    for (int op = 0; op < 8; op++) begin
      issue({op[2:0], 3'd5, 3'd3, 7'h40});
      repeat (4) @(negedge clk);
      issue({op[2:0], 3'd2, 3'd6, 7'h3F});
      repeat (4) @(negedge clk);
    end
    // all jump condition codes
    for (int c = 0; c < 8; c++) begin
      issue({3'd7, c[2:0], 10'h2A5});
      repeat (4) @(negedge clk);
    end

    latency(16'h2C4B, 3, "R4 hold-exec-adv latency");
    latency({3'd7, 3'd0, 10'h155}, 2, "R5 unconditional jump latency");
    latency({3'd7, 3'd1, 10'h155}, 3, "R4 conditional jump latency");

    // R8: fetch_go held high, instr changing every cycle while active
    @(negedge clk);
    fetch_go = 1'b1;
    instr    = 16'h1234;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      instr = 16'hF0F0 ^ i[15:0];
      @(negedge clk);
      check("R8 dst held while active", sel_dst, 3'd4);
    end
    for (int i = 0; i < 20; i++) begin
      instr = 16'h8000 + 16'(i * 977);
      @(negedge clk);
    end
    fetch_go = 1'b0;
    repeat (5) @(negedge clk);

    // R9: reset in the middle of a sequence
    issue(16'h0E3A);
    rst = 1'b1;
    @(negedge clk);
    check("R9 reset mid-sequence pc_en", pc_en, 0);
    check("R9 reset mid-sequence we",    reg_we, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      fetch_go = ($urandom_range(0, 2) != 0);
      instr    = 16'($urandom);
    end
    fetch_go = 1'b0;
    repeat (6) @(negedge clk);
    summary();
  end
endmodule